// File: doc/BRIEF.md
# Single-Level Interrupt Front End

This block is the interrupt entry logic for a simple single-cycle processor. A device raises an asynchronous request line. The block first passes that line through a synchronizer. If interrupts are currently open, it then captures the request in an acknowledge flip-flop. Capturing the request does three things in the same clock edge:

- it raises the acknowledge line back to the device;
- it emits a one-cycle alert toward the next-address logic;
- it closes interrupts by setting the mask flip-flop.

Software opens interrupts with an enable strobe and closes them with a disable strobe. The block also contains the processor's next-PC selector. In the cycle the alert is high, the selector forces the handler address. In every other cycle it picks the incremented PC, the jump target, the register target or the system-call entry according to a two-bit source code. Saving processor state and multi-level priority are not part of this block.

Top module: `intr_frontend`

## Requirements
- R1: While reset is high and after it is released, `irq_ack` and `irq_alert` are low and the mask is set, so interrupts start closed.
- R2: A request arriving while the mask is set produces no acknowledge and no alert.
- R3: With the mask clear, a request that rises is accepted `SYNC_STAGES`+1 clock edges later. At that edge `irq_ack` and `irq_alert` rise together.
- R4: `irq_alert` is high for exactly one cycle per accepted interrupt.
- R5: Accepting an interrupt sets the mask. A later request is therefore ignored until software enables interrupts again.
- R6: `irq_ack` stays high as long as the synchronized request stays high. It clears at the second clock edge after the request input falls (with `SYNC_STAGES`=1).
- R7: A one-cycle `int_enable` clears the mask and a one-cycle `int_disable` sets it. When both are high together, the mask ends set.
- R8: `next_pc` equals `HANDLER_ADDR` while `irq_alert` is high. Otherwise it follows `pc_src`: 0 selects `pc_incr`, 1 selects `jump_tgt`, 2 selects `reg_tgt`, and 3 selects `SYSCALL_ADDR`.
- R9: While `irq_ack` is still high, re-enabling interrupts does not accept the same held request a second time. A fresh request after the acknowledge clears is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Asynchronous device interrupt request |
| int_enable | input | 1 | Software strobe that clears the mask |
| int_disable | input | 1 | Software strobe that sets the mask |
| pc_src | input | 2 | Normal next-PC source code |
| pc_incr | input | PC_W | Incremented PC |
| jump_tgt | input | PC_W | Jump target |
| reg_tgt | input | PC_W | Register-held target |
| irq_ack | output | 1 | Acknowledge to the device |
| irq_alert | output | 1 | One-cycle notice to the next-address logic |
| next_pc | output | PC_W | Selected next PC |

## Verification
The hardest situation to reach is a request that is still held high while software has already reopened interrupts. The mask is then clear but the acknowledge is still set, and only the acknowledge keeps the same request from being taken twice. The stimulus gets there by holding the request line through an accepted interrupt and pulsing enable before releasing it. It then watches that no second alert appears, and finally drops and re-raises the request to show that a fresh one is accepted. The simultaneous enable and disable strobe is also driven, and is followed by a request so that the resulting mask state becomes visible at the ports.

// File: rtl/intr_pkg.sv
package intr_pkg;
  typedef enum logic [1:0] {
    SRC_INCR    = 2'd0,
    SRC_JUMP    = 2'd1,
    SRC_REG     = 2'd2,
    SRC_SYSCALL = 2'd3
  } pc_src_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic req_s,
  input  logic int_enable,
  input  logic int_disable,
  output logic ack,
  output logic alert
);
  logic mask;
  logic take;

  // accept only an open, fresh request
  assign take = req_s && !mask && !ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      alert <= 1'b0;
      mask  <= 1'b1;
    end else begin
      alert <= take;
      if (take)        ack <= 1'b1;
      else if (!req_s) ack <= 1'b0;
      if (take || int_disable) mask <= 1'b1;
      else if (int_enable)     mask <= 1'b0;
    end
  end

  assert_alert_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    alert |=> !alert);
  assert_alert_with_ack_R3: assert property (@(posedge clk) disable iff (rst)
    alert |-> ack);
  assert_mask_on_accept_R5: assert property (@(posedge clk) disable iff (rst)
    alert |-> mask);
  assert_disable_wins_R7: assert property (@(posedge clk) disable iff (rst)
    int_disable |=> mask);
  assert_ack_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (ack && req_s) |=> ack);
  assert_masked_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (mask && !ack) |=> !ack);
endmodule

// File: rtl/npc_mux.sv
module npc_mux
  import intr_pkg::*;
#(
  parameter int           PC_W         = 32,
  parameter logic [PC_W-1:0] HANDLER_ADDR = 32'h0000_0180,
  parameter logic [PC_W-1:0] SYSCALL_ADDR = 32'h0000_0080
) (
  input  logic            alert,
  input  logic [1:0]      src,
  input  logic [PC_W-1:0] pc_incr,
  input  logic [PC_W-1:0] jump_tgt,
  input  logic [PC_W-1:0] reg_tgt,
  output logic [PC_W-1:0] next_pc
);
  always_comb begin
    if (alert) next_pc = HANDLER_ADDR;
    else begin
      unique case (pc_src_e'(src))
        SRC_INCR:    next_pc = pc_incr;
        SRC_JUMP:    next_pc = jump_tgt;
        SRC_REG:     next_pc = reg_tgt;
        SRC_SYSCALL: next_pc = SYSCALL_ADDR;
        default:     next_pc = pc_incr;
      endcase
    end
  end
endmodule

// File: rtl/intr_frontend.sv
module intr_frontend #(
  parameter int              PC_W         = 32,
  parameter int              SYNC_STAGES  = 1,
  parameter logic [PC_W-1:0] HANDLER_ADDR = 32'h0000_0180,
  parameter logic [PC_W-1:0] SYSCALL_ADDR = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq_req,
  input  logic            int_enable,
  input  logic            int_disable,
  input  logic [1:0]      pc_src,
  input  logic [PC_W-1:0] pc_incr,
  input  logic [PC_W-1:0] jump_tgt,
  input  logic [PC_W-1:0] reg_tgt,
  output logic            irq_ack,
  output logic            irq_alert,
  output logic [PC_W-1:0] next_pc
);
  logic req_s;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_req), .q(req_s)
  );

  irq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .req_s(req_s),
    .int_enable(int_enable), .int_disable(int_disable),
    .ack(irq_ack), .alert(irq_alert)
  );

  npc_mux #(
    .PC_W(PC_W), .HANDLER_ADDR(HANDLER_ADDR), .SYSCALL_ADDR(SYSCALL_ADDR)
  ) u_mux (
    .alert(irq_alert), .src(pc_src), .pc_incr(pc_incr),
    .jump_tgt(jump_tgt), .reg_tgt(reg_tgt), .next_pc(next_pc)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq_ack && !irq_alert));
  assert_handler_pc_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_alert) |-> (next_pc == HANDLER_ADDR));
endmodule

// File: tb/sim_intr_frontend.sv
module sim_intr_frontend;
  localparam int          PC_W    = 32;
  localparam logic [31:0] HANDLER = 32'h0000_0180;
  localparam logic [31:0] SYSCALL = 32'h0000_0080;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_req = 1'b0, int_enable = 1'b0, int_disable = 1'b0;
  logic [1:0] pc_src = 2'd0;
  logic [PC_W-1:0] pc_incr = 32'h0000_1004, jump_tgt = 32'h0040_0000, reg_tgt = 32'h0000_2220;
  logic irq_ack, irq_alert;
  logic [PC_W-1:0] next_pc;

  int tests = 0;
  int fails = 0;

  intr_frontend u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .int_enable(int_enable),
    .int_disable(int_disable), .pc_src(pc_src), .pc_incr(pc_incr),
    .jump_tgt(jump_tgt), .reg_tgt(reg_tgt), .irq_ack(irq_ack),
    .irq_alert(irq_alert), .next_pc(next_pc)
  );

  always #4 clk = ~clk;

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; irq_req = 1'b0; int_enable = 1'b0; int_disable = 1'b0;
    tick(3);
    chk("R1 ack in reset", {31'd0, irq_ack}, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 ack after reset", {31'd0, irq_ack}, 0);
    chk("R1 alert after reset", {31'd0, irq_alert}, 0);
  endtask

  task automatic t_masked;
    irq_req = 1'b1;
    tick(4);
    chk("R2 masked ack", {31'd0, irq_ack}, 0);
    chk("R2 masked alert", {31'd0, irq_alert}, 0);
    irq_req = 1'b0;
    tick(2);
  endtask

  task automatic pulse_en;
    int_enable = 1'b1; tick(1); int_enable = 1'b0;
  endtask

  task automatic t_accept;
    pulse_en();
    pc_src = 2'd1;
    irq_req = 1'b1;
    tick(1);
    chk("R3 not yet", {31'd0, irq_ack}, 0);
    tick(1);
    chk("R3 ack rises", {31'd0, irq_ack}, 1);
    chk("R3 alert rises", {31'd0, irq_alert}, 1);
    chk("R8 handler pc", next_pc, HANDLER);
    tick(1);
    chk("R4 alert one cycle", {31'd0, irq_alert}, 0);
    chk("R8 jump after alert", next_pc, jump_tgt);
    chk("R6 ack held", {31'd0, irq_ack}, 1);
    tick(3);
    chk("R6 ack still held", {31'd0, irq_ack}, 1);
    irq_req = 1'b0;
    tick(1);
    chk("R6 ack one edge after drop", {31'd0, irq_ack}, 1);
    tick(1);
    chk("R6 ack cleared", {31'd0, irq_ack}, 0);
  endtask

  task automatic t_remask;
    irq_req = 1'b1;
    tick(4);
    chk("R5 second request ignored", {31'd0, irq_ack}, 0);
    irq_req = 1'b0;
    tick(2);
  endtask

  task automatic t_both;
    int_enable = 1'b1; int_disable = 1'b1; tick(1);
    int_enable = 1'b0; int_disable = 1'b0;
    irq_req = 1'b1;
    tick(4);
    chk("R7 disable wins", {31'd0, irq_ack}, 0);
    pulse_en();
    chk("R7 enable opens (not yet)", {31'd0, irq_ack}, 0);
    tick(1);
    chk("R7 enable opens", {31'd0, irq_ack}, 1);
    irq_req = 1'b0;
    tick(2);
    int_disable = 1'b1; tick(1); int_disable = 1'b0;
    irq_req = 1'b1;
    tick(4);
    chk("R7 disable closes", {31'd0, irq_ack}, 0);
    irq_req = 1'b0;
    tick(2);
  endtask

  task automatic t_held_reenable;
    int alerts;
    pulse_en();
    irq_req = 1'b1;
    tick(2);
    chk("R9 first accept", {31'd0, irq_alert}, 1);
    pulse_en();
    alerts = 0;
    for (int i = 0; i < 4; i++) begin
      if (irq_alert) alerts++;
      tick(1);
    end
    chk("R9 no second alert", alerts, 0);
    irq_req = 1'b0;
    tick(2);
    chk("R9 ack cleared", {31'd0, irq_ack}, 0);
    irq_req = 1'b1;
    tick(2);
    chk("R9 fresh accepted", {31'd0, irq_alert}, 1);
    irq_req = 1'b0;
    tick(3);
  endtask

  task automatic t_mux;
    pc_src = 2'd0; #1; chk("R8 incr", next_pc, pc_incr);
    pc_src = 2'd1; #1; chk("R8 jump", next_pc, jump_tgt);
    pc_src = 2'd2; #1; chk("R8 reg", next_pc, reg_tgt);
    pc_src = 2'd3; #1; chk("R8 syscall", next_pc, SYSCALL);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_masked();
        t_accept();
        t_remask();
        t_both();
        t_held_reenable();
        t_mux();
      end
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule